// File: doc/BRIEF.md
# Dual-Width YCbCr 4:2:2 Pixel Capture

This block receives 4:2:2 YCbCr video at the front of a video encoder. It runs from a double-rate pixel clock and derives a half-rate companion clock from it. It works in one of two bus widths. In the narrow width, chroma and luma bytes share one byte lane and arrive on every double-rate edge. In the wide width, luma arrives on the low lane and chroma on the high lane, and the block takes one sample for every period of the half-rate clock. Each complete pixel pair is presented as two luma samples, one Cb and one Cr, with a single-cycle valid strobe.

The line timing can come from outside. In that case the block samples the external blank and sync pins and uses the blank level to frame each active line. The line timing can also come from inside. As timing master, the block runs its own line and frame counters and drives blank and sync outputs. In the wide width, those outputs move only on edges of the opposite half-clock phase to the one used for sampling.

The width select is taken at reset and afterwards only while the line is blanked, so one line is never split across two widths. The half-rate clock is either generated internally or, in the wide width, taken from an external pin.

Top module: `ycc_capture`

## Requirements
- R1: While reset is held, out_valid, clk_out, samp_hsync, samp_vsync and sync_oe (with timing_master low) are all 0. Reset loads the width select from mode16_in (0 = narrow 8-bit, 1 = wide 16-bit).
- R2: clk_out inverts on every rising clk2 edge after reset. It is 1 after the first edge that follows reset.
- R3: In narrow mode, pix_lo is sampled on every clk2 edge. Active bytes are taken in the repeating order Cb, Y, Cr, Y. On the edge that samples the second Y, out_y0/out_y1/out_cb/out_cr take that group's values, and out_valid is 1 for exactly the following cycle.
- R4: Any sample taken with blank asserted returns the byte order to Cb. A partial group cut off by blank produces no pair.
- R5: In wide mode, samples are taken only on edges where the phase clock is 0. pix_lo carries Y and pix_hi carries chroma, Cb on the first pixel after blank and Cr on the next. A pair is emitted after the Cr pixel, with the same timing as in R3.
- R6: With clk_out_en = 0 in wide mode, clk_in is the phase clock, and no sample is taken while clk_in is 1. In narrow mode, clk_in has no effect.
- R7: The width select changes only on a sample edge where blank is asserted. A change of mode16_in during active video has no effect on capture.
- R8: In slave operation (timing_master = 0), samp_hsync and samp_vsync take hsync_in and vsync_in on sample edges only. In wide mode they hold on edges where the phase clock is 1.
- R9: With timing_master = 1, sync_oe = 1 and the internal timing drives blank_out, hsync_out and vsync_out. Its counters start at 0 after reset. The horizontal count advances by one per update edge and wraps at H_TOTAL, and the line count steps at each wrap. blank_out = (h >= H_ACTIVE or v >= V_ACTIVE), hsync_out = (h >= H_TOTAL - HS_W), vsync_out = (v >= V_TOTAL - VS_W).
- R10: As timing master in narrow mode, every edge is an update edge. In wide mode, only edges where the phase clock is 1 are update edges.
- R11: out_valid is never 1 in the cycle after a sample edge that saw blank asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2 | input | 1 | Double-rate pixel clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode16_in | input | 1 | Width select: 0 narrow, 1 wide |
| timing_master | input | 1 | 1: internal timing drives sync outputs |
| clk_out_en | input | 1 | 1: internal half clock drives clk_out and sets the phase |
| clk_in | input | 1 | External half clock (phase source in wide mode when clk_out_en is 0) |
| clk_out | output | 1 | Internal half-rate clock |
| pix_lo | input | PIX_W | Byte lane: multiplexed bytes or luma |
| pix_hi | input | PIX_W | Byte lane: chroma in wide mode |
| blank_in | input | 1 | External blank |
| hsync_in | input | 1 | External horizontal sync |
| vsync_in | input | 1 | External vertical sync |
| blank_out | output | 1 | Internal blank |
| hsync_out | output | 1 | Internal horizontal sync |
| vsync_out | output | 1 | Internal vertical sync |
| sync_oe | output | 1 | Enable for the sync/blank output drivers |
| samp_hsync | output | 1 | Sampled hsync_in |
| samp_vsync | output | 1 | Sampled vsync_in |
| out_y0 | output | PIX_W | First luma of pair |
| out_y1 | output | PIX_W | Second luma of pair |
| out_cb | output | PIX_W | Cb of pair |
| out_cr | output | PIX_W | Cr of pair |
| out_valid | output | 1 | One-cycle pair strobe |

## Verification
A byte-order counter stuck or off by one shows within one group of four bytes: bytes land in the wrong output fields, or the strobe comes a cycle early or late. A half-clock phase taken from the wrong edge sampling is visible in the wide width. It makes each wide pixel land in the wrong lane pairing, or it changes the sync outputs on the sampling phase, within two clk2 edges. A timing counter with a wrong wrap value shows on blank_out within one line and on vsync_out within one frame.

// File: rtl/ycc_cap_pkg.sv
package ycc_cap_pkg;
    localparam int PIX_W = 8;

    typedef enum logic {
        WIDTH_NARROW = 1'b0,
        WIDTH_WIDE   = 1'b1
    } cap_width_e;

    typedef struct packed {
        logic [PIX_W-1:0] y0;
        logic [PIX_W-1:0] y1;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] cr;
    } ycc_pair_t;

    typedef struct packed {
        logic blank;
        logic hsync;
        logic vsync;
    } vid_sync_t;
endpackage

// File: rtl/ycc_phase_gen.sv
module ycc_phase_gen
    import ycc_cap_pkg::*;
(
    input  logic       clk2,
    input  logic       rst_n,
    input  cap_width_e width,
    input  logic       clk_out_en,
    input  logic       clk_in,
    output logic       half_clk,
    output logic       phase,
    output logic       smp_stb,
    output logic       upd_stb
);
    logic half_d, half_q;

    always_comb begin
        half_d = ~half_q;
    end

    always_ff @(posedge clk2) begin
        if (!rst_n) half_q <= 1'b0;
        else        half_q <= half_d;
    end

    assign half_clk = half_q;
    // level of the companion clock just before the current clk2 edge
    assign phase    = clk_out_en ? half_q : clk_in;

    always_comb begin
        if (width == WIDTH_NARROW) begin
            smp_stb = 1'b1;
            upd_stb = 1'b1;
        end else begin
            smp_stb = ~phase;
            upd_stb = phase;
        end
    end
endmodule

// File: rtl/ycc_timing_gen.sv
module ycc_timing_gen
    import ycc_cap_pkg::*;
#(
    parameter int H_TOTAL  = 32,
    parameter int H_ACTIVE = 24,
    parameter int HS_W     = 4,
    parameter int V_TOTAL  = 8,
    parameter int V_ACTIVE = 6,
    parameter int VS_W     = 1
) (
    input  logic      clk2,
    input  logic      rst_n,
    input  logic      run,
    input  logic      step,
    output vid_sync_t sync
);
    localparam int HW = (H_TOTAL > 1) ? $clog2(H_TOTAL) : 1;
    localparam int VW = (V_TOTAL > 1) ? $clog2(V_TOTAL) : 1;
    localparam logic [HW-1:0] H_LAST  = HW'(H_TOTAL - 1);
    localparam logic [VW-1:0] V_LAST  = VW'(V_TOTAL - 1);
    localparam logic [HW-1:0] H_BLANK = HW'(H_ACTIVE);
    localparam logic [VW-1:0] V_BLANK = VW'(V_ACTIVE);
    localparam logic [HW-1:0] H_SYNC  = HW'(H_TOTAL - HS_W);
    localparam logic [VW-1:0] V_SYNC  = VW'(V_TOTAL - VS_W);

    typedef struct packed {
        logic [HW-1:0] h;
        logic [VW-1:0] v;
    } tg_state_t;

    tg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (run && step) begin
            if (st_q.h == H_LAST) begin
                st_d.h = '0;
                st_d.v = (st_q.v == V_LAST) ? '0 : st_q.v + 1'b1;
            end else begin
                st_d.h = st_q.h + 1'b1;
            end
        end
    end

    always_ff @(posedge clk2) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        sync.blank = (st_q.h >= H_BLANK) || (st_q.v >= V_BLANK);
        sync.hsync = (st_q.h >= H_SYNC);
        sync.vsync = (st_q.v >= V_SYNC);
    end
endmodule

// File: rtl/ycc_lane_unpack.sv
module ycc_lane_unpack
    import ycc_cap_pkg::*;
(
    input  logic             clk2,
    input  logic             rst_n,
    input  cap_width_e       width,
    input  logic             smp_stb,
    input  logic             blank,
    input  logic [PIX_W-1:0] lane_lo,
    input  logic [PIX_W-1:0] lane_hi,
    output ycc_pair_t        pair,
    output logic             pair_vld
);
    typedef struct packed {
        logic [1:0]       slot;
        logic [PIX_W-1:0] cb;
        logic [PIX_W-1:0] y0;
        logic [PIX_W-1:0] cr;
        ycc_pair_t        pair;
        logic             vld;
    } up_state_t;

    up_state_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.vld = 1'b0;
        if (smp_stb) begin
            if (blank) begin
                st_d.slot = 2'd0;
            end else if (width == WIDTH_NARROW) begin
                unique case (st_q.slot)
                    2'd0: st_d.cb = lane_lo;
                    2'd1: st_d.y0 = lane_lo;
                    2'd2: st_d.cr = lane_lo;
                    default: begin
                        st_d.pair.y0 = st_q.y0;
                        st_d.pair.y1 = lane_lo;
                        st_d.pair.cb = st_q.cb;
                        st_d.pair.cr = st_q.cr;
                        st_d.vld     = 1'b1;
                    end
                endcase
                st_d.slot = st_q.slot + 2'd1;
            end else begin
                if (!st_q.slot[0]) begin
                    st_d.y0   = lane_lo;
                    st_d.cb   = lane_hi;
                    st_d.slot = 2'd1;
                end else begin
                    st_d.pair.y0 = st_q.y0;
                    st_d.pair.y1 = lane_lo;
                    st_d.pair.cb = st_q.cb;
                    st_d.pair.cr = lane_hi;
                    st_d.vld     = 1'b1;
                    st_d.slot    = 2'd0;
                end
            end
        end
    end

    always_ff @(posedge clk2) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pair     = st_q.pair;
    assign pair_vld = st_q.vld;
endmodule

// File: rtl/ycc_capture.sv
module ycc_capture
    import ycc_cap_pkg::*;
#(
    parameter int H_TOTAL  = 32,
    parameter int H_ACTIVE = 24,
    parameter int HS_W     = 4,
    parameter int V_TOTAL  = 8,
    parameter int V_ACTIVE = 6,
    parameter int VS_W     = 1
) (
    input  logic             clk2,
    input  logic             rst_n,
    input  logic             mode16_in,
    input  logic             timing_master,
    input  logic             clk_out_en,
    input  logic             clk_in,
    output logic             clk_out,
    input  logic [PIX_W-1:0] pix_lo,
    input  logic [PIX_W-1:0] pix_hi,
    input  logic             blank_in,
    input  logic             hsync_in,
    input  logic             vsync_in,
    output logic             blank_out,
    output logic             hsync_out,
    output logic             vsync_out,
    output logic             sync_oe,
    output logic             samp_hsync,
    output logic             samp_vsync,
    output logic [PIX_W-1:0] out_y0,
    output logic [PIX_W-1:0] out_y1,
    output logic [PIX_W-1:0] out_cb,
    output logic [PIX_W-1:0] out_cr,
    output logic             out_valid
);
    typedef struct packed {
        cap_width_e width;
        logic       hs;
        logic       vs;
    } top_state_t;

    top_state_t st_d, st_q;
    cap_width_e cur_width;
    logic       cap_phase, smp_stb, upd_stb, blank_src;
    vid_sync_t  gen_sync;
    ycc_pair_t  pair;

    assign cur_width = st_q.width;

    ycc_phase_gen u_phase (
        .clk2       (clk2),
        .rst_n      (rst_n),
        .width      (cur_width),
        .clk_out_en (clk_out_en),
        .clk_in     (clk_in),
        .half_clk   (clk_out),
        .phase      (cap_phase),
        .smp_stb    (smp_stb),
        .upd_stb    (upd_stb)
    );

    ycc_timing_gen #(
        .H_TOTAL  (H_TOTAL),
        .H_ACTIVE (H_ACTIVE),
        .HS_W     (HS_W),
        .V_TOTAL  (V_TOTAL),
        .V_ACTIVE (V_ACTIVE),
        .VS_W     (VS_W)
    ) u_timing (
        .clk2  (clk2),
        .rst_n (rst_n),
        .run   (timing_master),
        .step  (upd_stb),
        .sync  (gen_sync)
    );

    assign blank_src = timing_master ? gen_sync.blank : blank_in;

    ycc_lane_unpack u_unpack (
        .clk2     (clk2),
        .rst_n    (rst_n),
        .width    (cur_width),
        .smp_stb  (smp_stb),
        .blank    (blank_src),
        .lane_lo  (pix_lo),
        .lane_hi  (pix_hi),
        .pair     (pair),
        .pair_vld (out_valid)
    );

    always_comb begin
        st_d = st_q;
        if (smp_stb) begin
            if (blank_src) st_d.width = cap_width_e'(mode16_in);
            if (!timing_master) begin
                st_d.hs = hsync_in;
                st_d.vs = vsync_in;
            end
        end
    end

    always_ff @(posedge clk2) begin
        if (!rst_n) begin
            st_q.width <= cap_width_e'(mode16_in);
            st_q.hs    <= 1'b0;
            st_q.vs    <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign samp_hsync = st_q.hs;
    assign samp_vsync = st_q.vs;
    assign sync_oe    = timing_master;
    assign blank_out  = gen_sync.blank;
    assign hsync_out  = gen_sync.hsync;
    assign vsync_out  = gen_sync.vsync;
    assign out_y0     = pair.y0;
    assign out_y1     = pair.y1;
    assign out_cb     = pair.cb;
    assign out_cr     = pair.cr;
endmodule

// File: rtl/ycc_capture_chk.sv
module ycc_capture_chk (
    input logic clk2,
    input logic rst_n,
    input logic timing_master,
    input logic out_valid,
    input logic clk_out,
    input logic wide,
    input logic blank_src,
    input logic cap_phase,
    input logic blank_out,
    input logic hsync_out,
    input logic vsync_out
);
    AST_HALF_TOGGLE: assert property (@(posedge clk2) disable iff (!rst_n)
        $past(rst_n) |-> (clk_out != $past(clk_out))); // R2

    AST_VALID_PULSE: assert property (@(posedge clk2) disable iff (!rst_n)
        out_valid |=> !out_valid); // R3

    AST_VALID_AFTER_ACTIVE: assert property (@(posedge clk2) disable iff (!rst_n)
        ($past(rst_n) && out_valid) |-> !$past(blank_src)); // R11

    AST_MODE_IN_BLANK: assert property (@(posedge clk2) disable iff (!rst_n)
        ($past(rst_n) && (wide != $past(wide))) |-> $past(blank_src)); // R7

    AST_SYNC16_HOLD: assert property (@(posedge clk2) disable iff (!rst_n)
        $past(rst_n && timing_master && wide && !cap_phase)
        |-> $stable({blank_out, hsync_out, vsync_out})); // R10
endmodule

bind ycc_capture ycc_capture_chk u_chk (
    .clk2          (clk2),
    .rst_n         (rst_n),
    .timing_master (timing_master),
    .out_valid     (out_valid),
    .clk_out       (clk_out),
    .wide          (cur_width == ycc_cap_pkg::WIDTH_WIDE),
    .blank_src     (blank_src),
    .cap_phase     (cap_phase),
    .blank_out     (blank_out),
    .hsync_out     (hsync_out),
    .vsync_out     (vsync_out)
);

// File: tb/ycc_capture_test.sv
module ycc_capture_test;
    localparam int PERIOD = 10;
    localparam int Q      = 2;
    localparam int NROW   = 12;

    logic       clk2 = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode16_in = 1'b0, timing_master = 1'b0, clk_out_en = 1'b0, clk_in = 1'b1;
    logic       clk_out;
    logic [7:0] pix_lo = '0, pix_hi = '0;
    logic       blank_in = 1'b1, hsync_in = 1'b0, vsync_in = 1'b0;
    logic       blank_out, hsync_out, vsync_out, sync_oe, samp_hsync, samp_vsync;
    logic [7:0] out_y0, out_y1, out_cb, out_cr;
    logic       out_valid;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // row: {blank, byte, expected valid, expected {y0,y1,cb,cr}}
    localparam logic [41:0] VEC [NROW] = '{
        {1'b1, 8'h00, 1'b0, 32'h0},
        {1'b0, 8'h10, 1'b0, 32'h0},
        {1'b0, 8'h20, 1'b0, 32'h0},
        {1'b0, 8'h30, 1'b0, 32'h0},
        {1'b0, 8'h40, 1'b1, 32'h20401030},
        {1'b0, 8'h11, 1'b0, 32'h0},
        {1'b0, 8'h21, 1'b0, 32'h0},
        {1'b1, 8'h99, 1'b0, 32'h0},
        {1'b0, 8'h12, 1'b0, 32'h0},
        {1'b0, 8'h22, 1'b0, 32'h0},
        {1'b0, 8'h32, 1'b0, 32'h0},
        {1'b0, 8'h42, 1'b1, 32'h22421232}
    };

    ycc_capture uut (
        .clk2(clk2), .rst_n(rst_n), .mode16_in(mode16_in), .timing_master(timing_master),
        .clk_out_en(clk_out_en), .clk_in(clk_in), .clk_out(clk_out),
        .pix_lo(pix_lo), .pix_hi(pix_hi), .blank_in(blank_in), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .blank_out(blank_out), .hsync_out(hsync_out),
        .vsync_out(vsync_out), .sync_oe(sync_oe), .samp_hsync(samp_hsync),
        .samp_vsync(samp_vsync), .out_y0(out_y0), .out_y1(out_y1), .out_cb(out_cb),
        .out_cr(out_cr), .out_valid(out_valid)
    );

    always #(PERIOD/2) clk2 = ~clk2;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic edge_q();
        @(posedge clk2);
        #Q;
    endtask

    // wide mode: wait until the next edge is a sampling edge (phase 0)
    task automatic step16(input logic b, input logic [7:0] lo, input logic [7:0] hi);
        @(negedge clk2);
        if (clk_out !== 1'b0) @(negedge clk2);
        blank_in = b; pix_lo = lo; pix_hi = hi;
        edge_q();
    endtask

    task automatic do_reset();
        @(negedge clk2);
        rst_n = 1'b0;
        repeat (4) @(negedge clk2);
        rst_n = 1'b1;
    endtask

    function automatic logic [31:0] pair_now();
        return {out_y0, out_y1, out_cb, out_cr};
    endfunction

    initial begin
        #(PERIOD * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic prev;
        int h, v;
        logic p;

        // R1: reset state
        repeat (3) @(negedge clk2);
        chk("R1 valid", {31'b0, out_valid}, 32'd0);
        chk("R1 clk_out", {31'b0, clk_out}, 32'd0);
        chk("R1 samp", {30'b0, samp_hsync, samp_vsync}, 32'd0);
        chk("R1 sync_oe", {31'b0, sync_oe}, 32'd0);
        rst_n = 1'b1;

        // R2: half clock toggles each edge
        edge_q();
        chk("R2 first", {31'b0, clk_out}, 32'd1);
        prev = clk_out;
        for (int i = 0; i < 4; i++) begin
            edge_q();
            chk("R2 toggle", {31'b0, clk_out}, {31'b0, ~prev});
            prev = clk_out;
        end

        // R3/R4/R11/R6: narrow vector table, clk_in held at 1 (ignored)
        for (int i = 0; i < NROW; i++) begin
            @(negedge clk2);
            blank_in = VEC[i][41];
            pix_lo   = VEC[i][40:33];
            edge_q();
            if (VEC[i][32]) begin
                chk((i < 7) ? "R3 valid" : "R4 valid", {31'b0, out_valid}, 32'd1);
                chk((i < 7) ? "R3 pair" : "R4 pair", pair_now(), VEC[i][31:0]);
            end else begin
                chk((i < 7) ? "R3 R6 idle" : "R4 R11 idle", {31'b0, out_valid}, 32'd0);
            end
        end
        edge_q();
        chk("R3 single pulse", {31'b0, out_valid}, 32'd0);

        // R8: narrow slave sync sampling
        @(negedge clk2);
        blank_in = 1'b1; hsync_in = 1'b1; vsync_in = 1'b1;
        edge_q();
        chk("R8 narrow", {30'b0, samp_hsync, samp_vsync}, 32'd3);
        @(negedge clk2);
        hsync_in = 1'b0; vsync_in = 1'b0;
        edge_q();

        // switch to wide during blank (R7)
        @(negedge clk2);
        clk_out_en = 1'b1; mode16_in = 1'b1;
        edge_q();

        // R5: wide lanes
        step16(1'b1, 8'h00, 8'h00);
        step16(1'b0, 8'h50, 8'h60);
        chk("R5 first pixel", {31'b0, out_valid}, 32'd0);
        step16(1'b0, 8'h51, 8'h61);
        chk("R5 valid", {31'b0, out_valid}, 32'd1);
        chk("R5 pair", pair_now(), 32'h50516061);
        edge_q();
        chk("R5 pulse end", {31'b0, out_valid}, 32'd0);

        // R7: mode input change during active ignored
        mode16_in = 1'b0;
        step16(1'b0, 8'h52, 8'h62);
        step16(1'b0, 8'h53, 8'h63);
        chk("R7 still wide", pair_now(), 32'h52536263);
        chk("R7 valid", {31'b0, out_valid}, 32'd1);
        mode16_in = 1'b1;

        // R8: wide slave, hold on phase-1 edge
        @(negedge clk2);
        hsync_in = 1'b1;
        edge_q();
        chk("R8 hold", {31'b0, samp_hsync}, 32'd0);
        edge_q();
        chk("R8 sample", {31'b0, samp_hsync}, 32'd1);
        hsync_in = 1'b0;

        // R6: external phase clock in wide mode
        step16(1'b1, 8'h00, 8'h00);
        @(negedge clk2);
        clk_out_en = 1'b0; clk_in = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 6; i++) begin
                @(negedge clk2);
                blank_in = 1'b0; pix_lo = 8'(8'h80 + i); pix_hi = 8'(8'h90 + i);
                edge_q();
                if (out_valid) seen++;
            end
            chk("R6 no sample while clk_in high", seen, 0);
        end
        @(negedge clk2);
        clk_in = 1'b0; blank_in = 1'b1;
        edge_q();
        @(negedge clk2);
        blank_in = 1'b0; pix_lo = 8'h70; pix_hi = 8'h80;
        edge_q();
        @(negedge clk2);
        pix_lo = 8'h71; pix_hi = 8'h81;
        edge_q();
        chk("R6 valid", {31'b0, out_valid}, 32'd1);
        chk("R6 pair", pair_now(), 32'h70718081);

        // R9: master, narrow
        @(negedge clk2);
        blank_in = 1'b1; clk_in = 1'b1; clk_out_en = 1'b1;
        mode16_in = 1'b0; timing_master = 1'b1;
        do_reset();
        chk("R9 oe", {31'b0, sync_oe}, 32'd1);
        chk("R9 initial", {29'b0, blank_out, hsync_out, vsync_out}, 32'd0);
        h = 0; v = 0;
        for (int i = 0; i < 300; i++) begin
            @(posedge clk2);
            if (h == 31) begin h = 0; v = (v == 7) ? 0 : v + 1; end else h++;
            #Q;
            chk("R9 sync", {29'b0, blank_out, hsync_out, vsync_out},
                {29'b0, (h >= 24) || (v >= 6), h >= 28, v >= 7});
        end

        // R10: master, wide (width loaded at reset)
        mode16_in = 1'b1;
        do_reset();
        h = 0; v = 0;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk2);
            p = clk_out;
            @(posedge clk2);
            if (p) begin
                if (h == 31) begin h = 0; v = (v == 7) ? 0 : v + 1; end else h++;
            end
            #Q;
            chk("R10 sync", {29'b0, blank_out, hsync_out, vsync_out},
                {29'b0, (h >= 24) || (v >= 6), h >= 28, v >= 7});
        end

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule